// File: doc/BRIEF.md
# Command Queue Thread Sequencer

This block is one execution thread of a command-queue engine. Once enabled, it walks a buffer of 64-bit instructions in memory. It starts at a current-address pointer and stops when that pointer equals an end-address pointer. It fetches one instruction at a time through a simple request/response memory read port. Jump instructions (relative or absolute) move the pointer. A wait-for-event instruction holds the thread until a chosen bit of an event input vector goes high. All other opcodes in the low range act as no-ops.

Software drives the thread through a small register window:

- warm reset, enable and suspend controls;
- a suspended status flag;
- interrupt status and enable;
- the current and end addresses;
- a wait-token view of the blocked event;
- a priority field.

A running thread can be retargeted in two ways. Software can suspend it, rewrite its pointers and resume it. Or, when the thread is parked at its end address, software can push the end address further out, which chains another buffer on without a restart. Faulting instructions halt the thread and raise an error flag until software rewrites the current address.

Top module: `cq_thread_seq`

## Requirements
- R1: After reset every register in the window reads zero, no fetch is requested, and both interrupt outputs are low.
- R2: While enabled, the thread fetches 8-byte-aligned instructions one at a time, with at most one outstanding request, in ascending order from the current address. An opcode (bits 63:56) in 0x00..0x0F is a no-op that advances the address by 8.
- R3: When the current address equals the end address at an instruction boundary, fetching stops and bit 0 of the status register (offset 0x10) is set. The bit stays set until software clears it.
- R4: An instruction with upper word 0x10000000 sets the current address to the current address plus the lower word. Upper word 0x10000001 sets the current address to the lower word.
- R5: Any other opcode sets status bit 1. A jump whose target has nonzero bits 2:0 sets status bit 4. In both cases the thread halts with the current address left on the faulting instruction.
- R6: Writing the current address (offset 0x20) discards any fetch in flight, restarts fetch from the written value, and releases a halted thread.
- R7: Opcode 0x20 with an event index in bits 7:0 blocks the thread until that bit of `evt_i` is high. Other event bits are ignored. While blocked, offset 0x30 reads bit 31 set with the index in the low bits.
- R8: Writing 1 to offset 0x08 pauses the thread at the next instruction boundary, or at once when it is waiting or parked. Bit 1 of offset 0x0C then reads 1. The pointers may be rewritten while paused, and writing 0 resumes fetch from the current address.
- R9: A thread parked at its end address resumes fetching when the end address (offset 0x24) is moved past the current address.
- R10: Writing 1 to bit 0 of offset 0x00 makes that bit read 1 for RST_CYC cycles and then 0. It clears enable, suspend and interrupt status, and abandons any fetch in flight.
- R11: A write to the status register clears each bit written 0 and keeps each bit written 1. `irq_done_o` is status bit 0 AND enable bit 0 (offset 0x14). `irq_err_o` is high when status bit 1 or bit 4 is set together with the matching enable bit.
- R12: Bit 0 of offset 0x04 starts execution. Writing 0 stops the thread at once, with no further fetch and the current address held.
- R13: Offset 0x40 stores a PRIO_W-bit priority value and reads it back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on reg_addr_i) |
| mem_req_o | output | 1 | Instruction fetch request, one cycle per fetch |
| mem_addr_o | output | 32 | Fetch byte address |
| mem_rvalid_i | input | 1 | Fetch response valid (responses return in order) |
| mem_rdata_i | input | 64 | Fetched instruction |
| evt_i | input | EVN | Event vector for wait-for-event |
| irq_done_o | output | 1 | Enabled completion interrupt |
| irq_err_o | output | 1 | Enabled error interrupt |

## Verification
The assertions check these on every cycle:

- fetch addresses are aligned and never back-to-back, so one request is in flight;
- no fetch is issued while the thread is suspended or in warm reset;
- the address is held while the thread is blocked on an event;
- the write-zero-clears and write-one-keeps rule of the status register, and the stickiness of the done bit.

Only the bench scenarios can show the end-to-end results:

- the order of fetched addresses across no-op runs and jumps;
- that a stale fetch response is dropped after the address is rewritten;
- that the thread releases on the selected event and no other;
- the resume-from-new-address behaviour after suspend;
- the chaining of a parked thread by moving its end address.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int unsigned AW   = 32;
  localparam int unsigned IW   = 64;
  localparam int unsigned RAW  = 8;
  localparam int unsigned IRQW = 5;
  localparam logic [IRQW-1:0] IRQ_IMPL = 5'b10011;
  localparam logic [IRQW-1:0] IRQ_ERR  = 5'b10010;

  localparam logic [RAW-1:0] OFS_WRST = 8'h00;
  localparam logic [RAW-1:0] OFS_EN   = 8'h04;
  localparam logic [RAW-1:0] OFS_SUSP = 8'h08;
  localparam logic [RAW-1:0] OFS_STAT = 8'h0C;
  localparam logic [RAW-1:0] OFS_IRQS = 8'h10;
  localparam logic [RAW-1:0] OFS_IRQE = 8'h14;
  localparam logic [RAW-1:0] OFS_CUR  = 8'h20;
  localparam logic [RAW-1:0] OFS_END  = 8'h24;
  localparam logic [RAW-1:0] OFS_TOK  = 8'h30;
  localparam logic [RAW-1:0] OFS_PRIO = 8'h40;

  localparam logic [7:0] OP_JUMP = 8'h10;
  localparam logic [7:0] OP_WFE  = 8'h20;

  typedef enum logic [2:0] {K_NOP, K_JMP, K_WFE, K_BAD_OP, K_BAD_TGT} kind_e;

  typedef struct packed {
    kind_e         kind;
    logic [AW-1:0] target;
    logic [7:0]    ev;
  } dec_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_WFE, ST_PARK, ST_SUSP, ST_HALT, ST_RST
  } st_e;
endpackage

// File: rtl/cq_decode.sv
module cq_decode import cq_pkg::*; #(
  parameter int unsigned EVN = 8
) (
  input  logic [IW-1:0] instr_i,
  input  logic [AW-1:0] cur_i,
  output dec_t          dec_o
);
  logic [7:0]  op;
  logic [23:0] sub;
  logic [31:0] lo;
  logic [AW-1:0] tgt;

  always_comb begin
    op  = instr_i[63:56];
    sub = instr_i[55:32];
    lo  = instr_i[31:0];
    tgt = sub[0] ? lo : cur_i + lo;
    dec_o.kind   = K_BAD_OP;
    dec_o.target = tgt;
    dec_o.ev     = lo[7:0];
    if (op[7:4] == 4'h0) begin
      dec_o.kind = K_NOP;
    end else if (op == OP_JUMP && sub[23:1] == 23'd0) begin
      dec_o.kind = (tgt[2:0] != 3'd0) ? K_BAD_TGT : K_JMP;
    end else if (op == OP_WFE && lo < 32'(EVN)) begin
      dec_o.kind = K_WFE;
    end
  end
endmodule

// File: rtl/cq_irq.sv
module cq_irq import cq_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IRQW-1:0] set_i,
  input  logic            clr_i,
  input  logic            wr_stat_i,
  input  logic            wr_ien_i,
  input  logic [IRQW-1:0] wdata_i,
  output logic [IRQW-1:0] stat_o,
  output logic [IRQW-1:0] ien_o,
  output logic            done_o,
  output logic            err_o
);
  logic [IRQW-1:0] stat_q, stat_d, ien_q;

  always_comb begin
    stat_d = stat_q;
    if (clr_i) begin
      stat_d = '0;
    end else begin
      if (wr_stat_i) stat_d = stat_d & wdata_i;
      stat_d = (stat_d | set_i) & IRQ_IMPL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      ien_q  <= '0;
    end else begin
      stat_q <= stat_d;
      if (wr_ien_i) ien_q <= wdata_i & IRQ_IMPL;
    end
  end

  assign stat_o = stat_q;
  assign ien_o  = ien_q;
  assign done_o = stat_q[0] & ien_q[0];
  assign err_o  = |(stat_q & ien_q & IRQ_ERR);

  assert_clear_on_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat_i && !wdata_i[0] && !set_i[0]) |=> !stat_o[0]);
  assert_keep_on_one_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat_i && wdata_i[1] && stat_o[1] && !clr_i) |=> stat_o[1]);
  assert_done_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[0] && !wr_stat_i && !clr_i) |=> stat_o[0]);
  assert_warm_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (stat_o == '0));
endmodule

// File: rtl/cq_thread_seq.sv
module cq_thread_seq import cq_pkg::*; #(
  parameter int unsigned EVN     = 8,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned RST_CYC = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [RAW-1:0] reg_addr_i,
  input  logic [31:0]    reg_wdata_i,
  output logic [31:0]    reg_rdata_o,
  output logic           mem_req_o,
  output logic [AW-1:0]  mem_addr_o,
  input  logic           mem_rvalid_i,
  input  logic [IW-1:0]  mem_rdata_i,
  input  logic [EVN-1:0] evt_i,
  output logic           irq_done_o,
  output logic           irq_err_o
);
  localparam int unsigned EVW = (EVN > 1) ? $clog2(EVN) : 1;
  localparam int unsigned RCW = $clog2(RST_CYC + 1);
  localparam logic [AW-1:0] STEP = AW'(8);

  st_e st_q, st_d;
  logic en_q, en_d, susp_q, susp_d, drop_q, drop_d;
  logic [AW-1:0] cur_q, cur_d, end_q, end_d;
  logic [PRIO_W-1:0] prio_q, prio_d;
  logic [EVW-1:0] wev_q, wev_d;
  logic [RCW-1:0] rcnt_q, rcnt_d;

  logic busy, wr_rst, wr_en, wr_susp, wr_irqs, wr_irqe, wr_cur, wr_end, wr_prio;
  logic ctl_wr, abandon, issue, accept;
  logic set_done, set_bad, set_tgt, clr_all;
  logic [IRQW-1:0] irq_stat, irq_ien;
  logic [AW-1:0] wmask;
  dec_t dec;
  logic unused_dec;

  assign busy    = (st_q == ST_RST);
  assign wr_rst  = reg_we_i && !busy && reg_addr_i == OFS_WRST;
  assign wr_en   = reg_we_i && !busy && reg_addr_i == OFS_EN;
  assign wr_susp = reg_we_i && !busy && reg_addr_i == OFS_SUSP;
  assign wr_irqs = reg_we_i && !busy && reg_addr_i == OFS_IRQS;
  assign wr_irqe = reg_we_i && !busy && reg_addr_i == OFS_IRQE;
  assign wr_cur  = reg_we_i && !busy && reg_addr_i == OFS_CUR;
  assign wr_end  = reg_we_i && !busy && reg_addr_i == OFS_END;
  assign wr_prio = reg_we_i && !busy && reg_addr_i == OFS_PRIO;
  assign wmask   = {reg_wdata_i[AW-1:3], 3'b000};

  assign ctl_wr  = wr_rst | wr_en | wr_susp | wr_cur | wr_end;
  assign abandon = wr_cur | (wr_en & ~reg_wdata_i[0]) | (wr_rst & reg_wdata_i[0]);
  assign issue   = (st_q == ST_ISSUE) && !susp_q && (cur_q != end_q) && !drop_q && !ctl_wr;
  assign accept  = (st_q == ST_WAIT) && mem_rvalid_i && !drop_q && !abandon;

  assign mem_req_o  = issue;
  assign mem_addr_o = cur_q;

  cq_decode #(.EVN(EVN)) u_dec (
    .instr_i(mem_rdata_i),
    .cur_i  (cur_q),
    .dec_o  (dec)
  );
  assign unused_dec = ^dec.ev;

  always_comb begin
    st_d = st_q; cur_d = cur_q; end_d = end_q; en_d = en_q; susp_d = susp_q;
    prio_d = prio_q; drop_d = drop_q; wev_d = wev_q; rcnt_d = rcnt_q;
    set_done = 1'b0; set_bad = 1'b0; set_tgt = 1'b0; clr_all = 1'b0;
    if (mem_rvalid_i && drop_q) drop_d = 1'b0;

    case (st_q)
      ST_RST: begin
        if (rcnt_q == '0) st_d = ST_IDLE;
        else rcnt_d = rcnt_q - 1'b1;
      end
      ST_IDLE: if (en_q) st_d = ST_ISSUE;
      ST_ISSUE: begin
        if (!ctl_wr) begin
          if (susp_q) st_d = ST_SUSP;
          else if (cur_q == end_q) begin
            st_d = ST_PARK;
            set_done = 1'b1;
          end else if (issue) st_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (accept) begin
          case (dec.kind)
            K_NOP: begin cur_d = cur_q + STEP; st_d = ST_ISSUE; end
            K_JMP: begin cur_d = dec.target; st_d = ST_ISSUE; end
            K_WFE: begin wev_d = dec.ev[EVW-1:0]; st_d = ST_WFE; end
            K_BAD_TGT: begin set_tgt = 1'b1; st_d = ST_HALT; end
            default: begin set_bad = 1'b1; st_d = ST_HALT; end
          endcase
        end
      end
      ST_WFE: begin
        if (evt_i[wev_q]) begin
          cur_d = cur_q + STEP;
          st_d  = ST_ISSUE;
        end else if (susp_q) st_d = ST_SUSP;
      end
      ST_PARK: begin
        if (susp_q) st_d = ST_SUSP;
        else if (cur_q != end_q) st_d = ST_ISSUE;
      end
      ST_SUSP: if (!susp_q) st_d = ST_ISSUE;
      default: ;
    endcase

    if (wr_susp) susp_d = reg_wdata_i[0];
    if (wr_end)  end_d  = wmask;
    if (wr_prio) prio_d = reg_wdata_i[PRIO_W-1:0];
    if (abandon && st_q == ST_WAIT) drop_d = !mem_rvalid_i;
    if (wr_cur) begin
      cur_d = wmask;
      if (st_q inside {ST_ISSUE, ST_WAIT, ST_WFE, ST_PARK, ST_HALT}) st_d = ST_ISSUE;
    end
    if (wr_en) begin
      en_d = reg_wdata_i[0];
      if (!reg_wdata_i[0]) st_d = ST_IDLE;
    end
    if (wr_rst && reg_wdata_i[0]) begin
      st_d    = ST_RST;
      rcnt_d  = RCW'(RST_CYC - 1);
      en_d    = 1'b0;
      susp_d  = 1'b0;
      wev_d   = '0;
      clr_all = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cur_q <= '0; end_q <= '0; en_q <= 1'b0; susp_q <= 1'b0;
      prio_q <= '0; drop_q <= 1'b0; wev_q <= '0; rcnt_q <= '0;
    end else begin
      st_q <= st_d; cur_q <= cur_d; end_q <= end_d; en_q <= en_d; susp_q <= susp_d;
      prio_q <= prio_d; drop_q <= drop_d; wev_q <= wev_d; rcnt_q <= rcnt_d;
    end
  end

  cq_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    ({set_tgt, 2'b00, set_bad, set_done}),
    .clr_i    (clr_all),
    .wr_stat_i(wr_irqs),
    .wr_ien_i (wr_irqe),
    .wdata_i  (reg_wdata_i[IRQW-1:0]),
    .stat_o   (irq_stat),
    .ien_o    (irq_ien),
    .done_o   (irq_done_o),
    .err_o    (irq_err_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFS_WRST: reg_rdata_o = {31'd0, busy};
      OFS_EN:   reg_rdata_o = {31'd0, en_q};
      OFS_SUSP: reg_rdata_o = {31'd0, susp_q};
      OFS_STAT: reg_rdata_o = {30'd0, st_q == ST_SUSP, 1'b0};
      OFS_IRQS: reg_rdata_o = 32'(irq_stat);
      OFS_IRQE: reg_rdata_o = 32'(irq_ien);
      OFS_CUR:  reg_rdata_o = cur_q;
      OFS_END:  reg_rdata_o = end_q;
      OFS_TOK:  reg_rdata_o = {st_q == ST_WFE, 31'(wev_q)};
      OFS_PRIO: reg_rdata_o = 32'(prio_q);
      default:  reg_rdata_o = '0;
    endcase
  end

  assert_req_aligned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[2:0] == 3'd0));
  assert_single_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  assert_no_req_susp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SUSP) |-> !mem_req_o);
  assert_wfe_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WFE && !evt_i[wev_q] && !reg_we_i) |=> $stable(cur_q));
  assert_rst_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !mem_req_o);
endmodule

// File: tb/test_cq_thread_seq.sv
module test_cq_thread_seq;
  localparam int unsigned EVN = 8;
  localparam int unsigned PRIO_W = 4;
  localparam int unsigned RST_CYC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_rvalid, irq_done, irq_err;
  logic [31:0] mem_addr;
  logic [63:0] mem_rdata;
  logic [EVN-1:0] evt = '0;

  int checks = 0, errors = 0;
  logic [63:0] mem [64];
  int lat = 1;
  logic [2:0] pv = '0;
  logic [63:0] pd0 = '0, pd1 = '0, pd2 = '0;
  int req_n = 0;
  logic [31:0] log_a [32];

  always #10 clk = ~clk;

  cq_thread_seq #(.EVN(EVN), .PRIO_W(PRIO_W), .RST_CYC(RST_CYC)) i_cq_thread_seq (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .evt_i(evt), .irq_done_o(irq_done), .irq_err_o(irq_err)
  );

  always @(posedge clk) begin
    pv  <= {pv[1:0], mem_req};
    pd0 <= mem[mem_addr[8:3]];
    pd1 <= pd0;
    pd2 <= pd1;
    if (mem_req) begin
      log_a[req_n % 32] <= mem_addr;
      req_n <= req_n + 1;
    end
  end
  assign mem_rvalid = (lat == 1) ? pv[0] : pv[2];
  assign mem_rdata  = (lat == 1) ? pd0 : pd2;

  function automatic logic [63:0] i_jrel(input logic [31:0] o); return {32'h10000000, o}; endfunction
  function automatic logic [63:0] i_jabs(input logic [31:0] t); return {32'h10000001, t}; endfunction
  function automatic logic [63:0] i_wfe(input logic [31:0] e); return {32'h20000000, e}; endfunction
  localparam logic [63:0] I_BAD = 64'hFF000000_00000000;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic poll(input logic [7:0] a, input logic [31:0] m, input logic [31:0] v,
                      input int maxc, output bit ok);
    logic [31:0] d;
    ok = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      rd(a, d);
      if ((d & m) == v) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic fill();
    for (int i = 0; i < 64; i++) mem[i] = {8'(i & 15), 56'd0};
  endtask

  task automatic restart();
    bit ok;
    wr(8'h00, 32'h1);
    poll(8'h00, 32'h1, 32'h0, 20, ok);
    fill();
  endtask

  task automatic go(input logic [31:0] s, input logic [31:0] e);
    wr(8'h24, e); wr(8'h20, s); wr(8'h04, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit ok;
    int base, n;
    fill();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    begin
      logic [7:0] offs [10] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h20, 8'h24, 8'h30, 8'h40};
      for (int i = 0; i < 10; i++) begin rd(offs[i], d); chk("R1 reg", d, 0); end
    end
    chk("R1 req", 32'(mem_req), 0);
    chk("R1 irq", {30'd0, irq_done, irq_err}, 0);

    // R13 priority readback
    wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, d); chk("R13 prio", d, (1 << PRIO_W) - 1);
    wr(8'h40, 32'h5); rd(8'h40, d); chk("R13 prio", d, 32'h5);

    // R2 R3 no-op runs of several lengths
    for (int len = 1; len <= 4; len++) begin
      restart();
      wr(8'h14, 32'h13);
      base = req_n;
      go(32'h100, 32'h100 + 8 * len);
      poll(8'h10, 32'h1, 32'h1, 200, ok);
      chk("R3 done", 32'(ok), 1);
      chk("R2 count", req_n - base, len);
      for (int k = 0; k < len; k++) chk("R2 order", log_a[(base + k) % 32], 32'h100 + 8 * k);
      rd(8'h20, d); chk("R3 cur at end", d, 32'h100 + 8 * len);
      repeat (10) @(negedge clk);
      chk("R3 no more fetch", req_n - base, len);
      chk("R11 done irq", 32'(irq_done), 1);
    end

    // R4 relative jumps
    for (int j = 2; j <= 4; j++) begin
      restart();
      mem[32] = i_jrel(32'(8 * j));
      base = req_n;
      go(32'h100, 32'h100 + 8 * j + 8);
      poll(8'h10, 32'h1, 32'h1, 200, ok);
      chk("R4 rel done", 32'(ok), 1);
      chk("R4 rel count", req_n - base, 2);
      chk("R4 rel target", log_a[(base + 1) % 32], 32'h100 + 8 * j);
    end

    // R4 absolute jump
    restart();
    mem[32] = i_jabs(32'h1C0);
    base = req_n;
    go(32'h100, 32'h1C8);
    poll(8'h10, 32'h1, 32'h1, 200, ok);
    chk("R4 abs count", req_n - base, 2);
    chk("R4 abs target", log_a[(base + 1) % 32], 32'h1C0);

    // R5 unknown opcode, R6 release
    restart();
    wr(8'h14, 32'h12);
    mem[33] = I_BAD;
    base = req_n;
    go(32'h100, 32'h120);
    poll(8'h10, 32'h2, 32'h2, 200, ok);
    rd(8'h10, d); chk("R5 bad op stat", d, 32'h2);
    rd(8'h20, d); chk("R5 bad op cur", d, 32'h108);
    chk("R11 err irq", {30'd0, irq_err, irq_done}, 32'h2);
    repeat (10) @(negedge clk);
    chk("R5 held", req_n - base, 2);
    wr(8'h20, 32'h110);
    poll(8'h10, 32'h1, 32'h1, 200, ok);
    rd(8'h10, d); chk("R6 release", d, 32'h3);

    // R5 misaligned jump target
    restart();
    mem[32] = i_jabs(32'h1C4);
    go(32'h100, 32'h120);
    poll(8'h10, 32'h10, 32'h10, 200, ok);
    rd(8'h10, d); chk("R5 bad target stat", d, 32'h10);
    rd(8'h20, d); chk("R5 bad target cur", d, 32'h100);

    // R6 stale fetch dropped
    restart();
    lat = 3;
    mem[32] = I_BAD;
    base = req_n;
    go(32'h100, 32'h150);
    while (req_n == base) @(negedge clk);
    wr(8'h20, 32'h140);
    poll(8'h10, 32'h1, 32'h1, 200, ok);
    rd(8'h10, d); chk("R6 drop stat", d, 32'h1);
    chk("R6 drop count", req_n - base, 3);
    chk("R6 drop order", log_a[(base + 1) % 32], 32'h140);
    lat = 1;

    // R7 wait for event
    restart();
    mem[32] = i_wfe(32'd5);
    go(32'h100, 32'h110);
    poll(8'h30, 32'h8000_0000, 32'h8000_0000, 100, ok);
    rd(8'h30, d); chk("R7 token", d, 32'h8000_0005);
    evt = 8'hDF;
    repeat (5) @(negedge clk);
    rd(8'h30, d); chk("R7 other events ignored", d, 32'h8000_0005);
    rd(8'h20, d); chk("R7 cur held", d, 32'h100);
    evt = 8'h20;
    poll(8'h10, 32'h1, 32'h1, 100, ok);
    evt = '0;
    rd(8'h20, d); chk("R7 released", d, 32'h110);

    // R8 suspend while waiting, retarget, resume
    restart();
    mem[32] = i_wfe(32'd2);
    go(32'h100, 32'h110);
    poll(8'h30, 32'h8000_0000, 32'h8000_0000, 100, ok);
    wr(8'h08, 32'h1);
    poll(8'h0C, 32'h2, 32'h2, 50, ok);
    chk("R8 suspended", 32'(ok), 1);
    rd(8'h30, d); chk("R8 not waiting", d[31], 0);
    wr(8'h20, 32'h120); wr(8'h24, 32'h130);
    base = req_n;
    repeat (5) @(negedge clk);
    chk("R8 no fetch", req_n - base, 0);
    wr(8'h08, 32'h0);
    poll(8'h10, 32'h1, 32'h1, 100, ok);
    chk("R8 resume count", req_n - base, 2);
    chk("R8 resume addr", log_a[base % 32], 32'h120);

    // R9 chain by moving end, R11 write-0 clears and write-1 keeps
    restart();
    base = req_n;
    go(32'h100, 32'h108);
    poll(8'h10, 32'h1, 32'h1, 100, ok);
    wr(8'h14, 32'h0);
    chk("R11 masked", 32'(irq_done), 0);
    wr(8'h10, 32'h1); rd(8'h10, d); chk("R11 keep", d, 32'h1);
    wr(8'h10, 32'h0); rd(8'h10, d); chk("R11 clear", d, 32'h0);
    wr(8'h24, 32'h118);
    poll(8'h10, 32'h1, 32'h1, 100, ok);
    chk("R9 chained count", req_n - base, 3);
    rd(8'h20, d); chk("R9 chained cur", d, 32'h118);

    // R12 enable off stops at once
    restart();
    go(32'h100, 32'h1F8);
    repeat (6) @(negedge clk);
    wr(8'h04, 32'h0);
    base = req_n;
    rd(8'h20, d);
    repeat (10) @(negedge clk);
    chk("R12 stopped", req_n - base, 0);
    begin
      logic [31:0] d2;
      rd(8'h20, d2); chk("R12 cur held", d2, d);
    end

    // R10 warm reset while running
    restart();
    wr(8'h14, 32'h13);
    mem[32] = I_BAD;
    go(32'h100, 32'h1F8);
    poll(8'h10, 32'h2, 32'h2, 100, ok);
    wr(8'h08, 32'h1);
    wr(8'h00, 32'h1);
    n = 0;
    rd(8'h00, d);
    while (d[0] && n < 50) begin n++; @(negedge clk); rd(8'h00, d); end
    chk("R10 busy cycles", n, RST_CYC);
    rd(8'h04, d); chk("R10 enable cleared", d, 0);
    rd(8'h08, d); chk("R10 suspend cleared", d, 0);
    rd(8'h10, d); chk("R10 status cleared", d, 0);
    base = req_n;
    repeat (5) @(negedge clk);
    chk("R10 idle", req_n - base, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule